// File: doc/BRIEF.md
# Vector Lane Permute Crossbar

This block rearranges 16-bit elements across the 32 lanes of a vector. Every output lane carries its own index, taken from a control vector, and copies one whole element from one source vector or from the 64-lane concatenation of two source vectors. A dual mode produces two independent permutations of the same source pair in one operation. A predicated form keeps the prior destination value in every lane whose predicate bit is clear, as a read-modify-write.

The unit is a fixed-latency pipeline that accepts one operation per cycle. The control vector, mode and predicate-enable arrive with the issue strobe. The data operands arrive two cycles later: both sources, the per-lane predicate and the prior destination vectors. During those two cycles the index decode runs ahead of the data mux. The result appears one cycle after the data, with a valid flag.

Top module: `lane_xbar`

## Requirements
- R1: With mode code 0 (shuffle), output lane k of `out_vec0` equals lane ctrl[k][4:0] of `d_vr`, and control bits 15:5 of that lane have no effect.
- R2: With mode code 1 (select), idx = ctrl[k][5:0]. Output lane k is `d_vr` lane idx when idx < 32 and `d_vs` lane idx-32 otherwise. Control bits 15:6 have no effect.
- R3: With mode code 2 (dual), `out_vec0` lane k is chosen by ctrl[k][5:0] and `out_vec1` lane k by ctrl[k][13:8], both over {d_vs, d_vr} as in R2. Bits 7:6 and 15:14 have no effect.
- R4: In shuffle and select operations, `out_vec1` is all zero.
- R5: With `in_pred_en` = 1, a lane whose `d_pred` bit is 0 takes `d_prior0` on `out_vec0`, and in dual mode also takes `d_prior1` on `out_vec1`. Lanes with the bit set are permuted normally. With `in_pred_en` = 0, `d_pred` has no effect.
- R6: An element moves as a whole 16-bit unit, and its two bytes stay together and in order.
- R7: The control, mode and predicate-enable are sampled with `in_valid` in cycle t. The data operands are sampled in cycle t+2. The result and `out_valid` = 1 appear in cycle t+3, and `out_valid` is 0 in every cycle without a result.
- R8: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles.
- R9: After reset, `out_valid` is 0 and both result vectors are zero.
- R10: Mode code 3 behaves exactly as shuffle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for control, mode and predicate-enable |
| in_mode | input | 2 | 0 shuffle, 1 select, 2 dual, 3 shuffle |
| in_pred_en | input | 1 | Enables the per-lane predicate |
| in_ctrl | input | 512 | Per-lane control words, lane k at bits 16k+15:16k |
| d_vr | input | 512 | First source vector, presented two cycles after issue |
| d_vs | input | 512 | Second source vector, presented two cycles after issue |
| d_pred | input | 32 | Per-lane predicate, bit k for lane k |
| d_prior0 | input | 512 | Prior value of the first destination |
| d_prior1 | input | 512 | Prior value of the second destination |
| out_valid | output | 1 | Result valid |
| out_vec0 | output | 512 | First result vector |
| out_vec1 | output | 512 | Second result vector (dual mode) |

## Verification
The hardest case to reach is several operations in flight at once. Three different operations sit in separate stages, so the control of one operation meets the data of an operation issued two cycles earlier. A routing or predicate decision that lands in the wrong stage only shows up under that overlap. The stream test issues shuffle, dual-predicated and select operations on consecutive cycles, and drives each data set exactly two cycles after its control. Every output is then compared with a lane model kept in the bench. The control words carry set bits above the index fields, so a mode that decodes too many index bits picks a different lane.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;
    localparam int LANES    = 32;
    localparam int EW       = 16;
    localparam int VW       = LANES * EW;
    localparam int SIDXW    = $clog2(LANES);
    localparam int IDXW     = $clog2(2 * LANES);
    localparam int IDX1_LSB = 8;

    typedef enum logic [1:0] {
        XM_SHFL = 2'd0,
        XM_SEL  = 2'd1,
        XM_DUAL = 2'd2,
        XM_RSVD = 2'd3
    } xbar_mode_e;

    typedef logic [IDXW-1:0] lane_idx_t;

    typedef struct packed {
        logic       valid;
        xbar_mode_e mode;
        logic       pred_en;
        logic [VW-1:0] ctrl;
    } xbar_issue_t;

    typedef struct packed {
        logic valid;
        logic dual;
        logic pred_en;
        logic [LANES*IDXW-1:0] idx0;
        logic [LANES*IDXW-1:0] idx1;
    } xbar_route_t;

    function automatic logic mode_is_wide(input xbar_mode_e m);
        return (m == XM_SEL) || (m == XM_DUAL);
    endfunction

    function automatic lane_idx_t idx_primary(input logic [EW-1:0] c, input logic wide);
        return wide ? c[IDXW-1:0] : {1'b0, c[SIDXW-1:0]};
    endfunction

    function automatic lane_idx_t idx_second(input logic [EW-1:0] c);
        return c[IDX1_LSB +: IDXW];
    endfunction
endpackage

// File: rtl/xbar_route_decode.sv
module xbar_route_decode
    import lane_xbar_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  xbar_issue_t issue_in,
    output xbar_route_t route_q
);
    xbar_issue_t issue_q;
    xbar_route_t route_d;
    logic        wide;
    logic [LANES-1:0] top_bits;

    always_ff @(posedge clk) begin
        if (rst) issue_q <= '0;
        else     issue_q <= issue_in;
    end

    assign wide = mode_is_wide(issue_q.mode);

    always_comb begin
        route_d.valid   = issue_q.valid;
        route_d.dual    = (issue_q.mode == XM_DUAL);
        route_d.pred_en = issue_q.pred_en;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [EW-1:0] cw;
        assign cw = issue_q.ctrl[k*EW +: EW];
        assign route_d.idx0[k*IDXW +: IDXW] = idx_primary(cw, wide);
        assign route_d.idx1[k*IDXW +: IDXW] = (issue_q.mode == XM_DUAL) ? idx_second(cw) : '0;
        assign top_bits[k] = route_q.idx0[k*IDXW + IDXW - 1];
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= '0;
        else     route_q <= route_d;
    end

    // R1 / R10: narrow modes never reach the second source
    assert_shfl_narrow_R1: assert property (@(posedge clk) disable iff (rst)
        route_q.valid && !$past(wide) |-> top_bits == '0);

    // R7: decode stage follows the issue stage by one cycle
    assert_decode_follow_R7: assert property (@(posedge clk) disable iff (rst)
        route_q.valid == $past(issue_q.valid));
endmodule

// File: rtl/xbar_lane_mux.sv
module xbar_lane_mux
    import lane_xbar_pkg::*;
(
    input  logic [LANES*IDXW-1:0] idx,
    input  logic                  en,
    input  logic                  keep_en,
    input  logic [LANES-1:0]      pred,
    input  logic [VW-1:0]         vr,
    input  logic [VW-1:0]         vs,
    input  logic [VW-1:0]         prior,
    output logic [VW-1:0]         vout
);
    logic [2*VW-1:0] pool;
    assign pool = {vs, vr};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_idx_t     li;
        logic [EW-1:0] picked;
        assign li     = idx[k*IDXW +: IDXW];
        assign picked = pool[int'(li)*EW +: EW];
        always_comb begin
            if (!en)                      vout[k*EW +: EW] = '0;
            else if (keep_en && !pred[k]) vout[k*EW +: EW] = prior[k*EW +: EW];
            else                          vout[k*EW +: EW] = picked;
        end
    end
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
    import lane_xbar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_mode,
    input  logic                 in_pred_en,
    input  logic [LANES*EW-1:0]  in_ctrl,
    input  logic [LANES*EW-1:0]  d_vr,
    input  logic [LANES*EW-1:0]  d_vs,
    input  logic [LANES-1:0]     d_pred,
    input  logic [LANES*EW-1:0]  d_prior0,
    input  logic [LANES*EW-1:0]  d_prior1,
    output logic                 out_valid,
    output logic [LANES*EW-1:0]  out_vec0,
    output logic [LANES*EW-1:0]  out_vec1
);
    xbar_issue_t issue;
    xbar_route_t route;
    logic [VW-1:0] mux0, mux1;

    always_comb begin
        issue.valid   = in_valid;
        issue.mode    = xbar_mode_e'(in_mode);
        issue.pred_en = in_pred_en;
        issue.ctrl    = in_ctrl;
    end

    xbar_route_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .issue_in (issue),
        .route_q  (route)
    );

    xbar_lane_mux u_mux0 (
        .idx     (route.idx0),
        .en      (1'b1),
        .keep_en (route.pred_en),
        .pred    (d_pred),
        .vr      (d_vr),
        .vs      (d_vs),
        .prior   (d_prior0),
        .vout    (mux0)
    );

    xbar_lane_mux u_mux1 (
        .idx     (route.idx1),
        .en      (route.dual),
        .keep_en (route.pred_en),
        .pred    (d_pred),
        .vr      (d_vr),
        .vs      (d_vs),
        .prior   (d_prior1),
        .vout    (mux1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec0  <= '0;
            out_vec1  <= '0;
        end else begin
            out_valid <= route.valid;
            if (route.valid) begin
                out_vec0 <= mux0;
                out_vec1 <= mux1;
            end
        end
    end

    // R7: result strobe one cycle after the decode stage
    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(route.valid));

    // R4: second result is empty outside dual mode
    assert_second_zero_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(route.dual) |-> out_vec1 == '0);

    // R5: a killed lane 0 returns the prior destination
    assert_kill_lane0_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(route.pred_en) && !$past(d_pred[0])
        |-> out_vec0[EW-1:0] == $past(d_prior0[EW-1:0]));

    // R8: results are never unknown
    assert_no_x_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown({out_vec0, out_vec1}));
endmodule

// File: tb/sim_lane_xbar.sv
module sim_lane_xbar;
    localparam int L = 32;
    localparam int W = 16;
    localparam int V = L * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = '0;
    logic         in_pred_en = 1'b0;
    logic [V-1:0] in_ctrl = '0;
    logic [V-1:0] d_vr = '0, d_vs = '0, d_prior0 = '0, d_prior1 = '0;
    logic [L-1:0] d_pred = '0;
    logic         out_valid;
    logic [V-1:0] out_vec0, out_vec1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lane_xbar u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_pred_en(in_pred_en), .in_ctrl(in_ctrl), .d_vr(d_vr), .d_vs(d_vs),
        .d_pred(d_pred), .d_prior0(d_prior0), .d_prior1(d_prior1),
        .out_valid(out_valid), .out_vec0(out_vec0), .out_vec1(out_vec1)
    );

    typedef struct {
        logic [1:0]   mode;
        logic         pen;
        logic [V-1:0] ctrl;
        logic [V-1:0] vr, vs, p0, p1;
        logic [L-1:0] pred;
    } op_t;

    // reference lane model, written from the requirements
    function automatic logic [V-1:0] model(input op_t o, input bit second);
        logic [V-1:0] r = '0;
        for (int k = 0; k < L; k++) begin
            logic [W-1:0] c = o.ctrl[k*W +: W];
            int idx;
            logic [W-1:0] e;
            bit dual = (o.mode == 2'd2);
            if (second && !dual) continue;
            if (o.mode == 2'd0 || o.mode == 2'd3) idx = int'(c[4:0]);
            else if (second)                      idx = int'(c[13:8]);
            else                                  idx = int'(c[5:0]);
            e = (idx < 32) ? o.vr[idx*W +: W] : o.vs[(idx-32)*W +: W];
            if (o.pen && !o.pred[k]) e = second ? o.p1[k*W +: W] : o.p0[k*W +: W];
            r[k*W +: W] = e;
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [V-1:0] act, input logic [V-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic op_t base_op();
        op_t o;
        o.mode = 0; o.pen = 0; o.ctrl = '0; o.pred = '1;
        for (int k = 0; k < L; k++) begin
            o.vr[k*W +: W] = {8'(8'h10 + k), 8'(8'h80 + k)};
            o.vs[k*W +: W] = {8'(8'h50 + k), 8'(8'hE0 - k)};
            o.p0[k*W +: W] = {8'hC0, 8'(k)};
            o.p1[k*W +: W] = {8'hD0, 8'(k)};
        end
        return o;
    endfunction

    task automatic run_op(input string tag, input op_t o);
        @(negedge clk);
        in_valid = 1; in_mode = o.mode; in_pred_en = o.pen; in_ctrl = o.ctrl;
        @(negedge clk);
        in_valid = 0; in_ctrl = '1; in_mode = 2'd2; in_pred_en = 1;
        @(negedge clk);
        check_bit({tag, " R7 no early valid"}, out_valid, 1'b0);
        d_vr = o.vr; d_vs = o.vs; d_pred = o.pred; d_prior0 = o.p0; d_prior1 = o.p1;
        @(negedge clk);
        check_bit({tag, " R7 valid"}, out_valid, 1'b1);
        check_vec({tag, " vec0"}, out_vec0, model(o, 0));
        check_vec({tag, " vec1"}, out_vec1, model(o, 1));
        d_vr = '1; d_vs = '1; d_pred = '0;
        @(negedge clk);
        check_bit({tag, " R7 valid drops"}, out_valid, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check_bit("R9 valid", out_valid, 1'b0);
        check_vec("R9 vec0", out_vec0, '0);
        check_vec("R9 vec1", out_vec1, '0);
        rst = 0;
    endtask

    task automatic t_shuffle();
        op_t o = base_op();
        for (int k = 0; k < L; k++) o.ctrl[k*W +: W] = {11'h5A5, 5'((k*7) % 32)} | 16'h0020;
        run_op("R1 R4 R6 shuffle", o);
    endtask

    task automatic t_select();
        op_t o = base_op();
        o.mode = 1;
        for (int k = 0; k < L; k++) o.ctrl[k*W +: W] = {10'h2C3, 6'((k*5 + 3) % 64)};
        run_op("R2 R4 select", o);
    endtask

    task automatic t_dual();
        op_t o = base_op();
        o.mode = 2;
        for (int k = 0; k < L; k++)
            o.ctrl[k*W +: W] = {2'b11, 6'((k + 40) % 64), 2'b11, 6'(63 - 2*k)};
        run_op("R3 dual", o);
    endtask

    task automatic t_pred();
        op_t o = base_op();
        o.mode = 1; o.pen = 1; o.pred = 32'h5A5A_0F0E;
        for (int k = 0; k < L; k++) o.ctrl[k*W +: W] = 16'(63 - k);
        run_op("R5 pred select", o);
        o.mode = 2; o.pred = 32'h8001_7FFE;
        for (int k = 0; k < L; k++) o.ctrl[k*W +: W] = {2'b00, 6'(k), 2'b00, 6'(k + 32)};
        run_op("R5 pred dual", o);
        o.pen = 0; o.pred = '0;
        run_op("R5 pred ignored", o);
    endtask

    task automatic t_mode3();
        op_t o = base_op();
        o.mode = 3;
        for (int k = 0; k < L; k++) o.ctrl[k*W +: W] = 16'hFFE0 | 16'(31 - k);
        run_op("R10 mode3", o);
    endtask

    task automatic t_stream();
        op_t ops[3];
        ops[0] = base_op();
        for (int k = 0; k < L; k++) ops[0].ctrl[k*W +: W] = 16'hFFE0 | 16'((k + 3) % 32);
        ops[1] = base_op(); ops[1].mode = 2; ops[1].pen = 1; ops[1].pred = 32'hF0F0_3C3C;
        for (int k = 0; k < L; k++) ops[1].ctrl[k*W +: W] = {2'b10, 6'(2*k), 2'b01, 6'(63 - k)};
        ops[2] = base_op(); ops[2].mode = 1;
        for (int k = 0; k < L; k++) ops[2].ctrl[k*W +: W] = 16'hFFC0 | 16'((k*9) % 64);
        for (int k = 0; k < L; k++) begin
            ops[2].vr[k*W +: W] = 16'(16'h7000 + 3*k);
            ops[1].vs[k*W +: W] = 16'(16'h2100 + 5*k);
        end
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            if (c >= 3 && c < 6) begin
                check_bit("R8 stream valid", out_valid, 1'b1);
                check_vec("R8 stream vec0", out_vec0, model(ops[c-3], 0));
                check_vec("R8 stream vec1", out_vec1, model(ops[c-3], 1));
            end
            if (c < 3) begin
                in_valid = 1; in_mode = ops[c].mode; in_pred_en = ops[c].pen; in_ctrl = ops[c].ctrl;
            end else begin
                in_valid = 0;
            end
            if (c >= 2 && c < 5) begin
                d_vr = ops[c-2].vr; d_vs = ops[c-2].vs; d_pred = ops[c-2].pred;
                d_prior0 = ops[c-2].p0; d_prior1 = ops[c-2].p1;
            end
        end
        check_bit("R8 stream idle", out_valid, 1'b0);
    endtask

    initial begin
        t_reset();
        t_shuffle();
        t_select();
        t_dual();
        t_pred();
        t_mode3();
        t_stream();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule